// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

The meter measures how fast an externally selected clock runs. It counts edges of that clock while a gating window runs for a set number of cycles of a known reference clock. Software writes one control word. That word holds the window length, a monitor-clock selector, a divider code and a reference choice. The selector and the divider code are driven out to the clock mux that sits outside the block. After an arming sequence, software sets the enable bit. It then polls the result word and computes the frequency as count × f_ref / window length.

Three clock domains are used. The register file runs on the bus clock. The window counter runs on the chosen reference clock, which is either a fast or a slow reference. The edge counter runs on the monitored clock. A toggle carries the start request into the reference domain, and the window level passes into the monitored domain. The finished flag returns to the bus domain. Each of these crossings uses a two-flop synchronizer. A soft-reset bit clears all measurement state in every domain. It leaves the programmed fields untouched.

Top module: `freq_meter`

## Requirements
- R1: After rstN the control word (offset 0x10) reads 0, the result word (offset 0x14) reads 0, and monSel and monDiv are 0.
- R2: A write to 0x10 with bit 14 = 0 stores the window field [11:0], enable [15], monitor select [22:16], reference code [25:24] and divider code [29:28]. A read of 0x10 returns exactly those bits, with all other bits 0. monSel and monDiv follow the stored fields.
- R3: A write to 0x10 with bit 14 = 1 sets the soft-reset bit, which reads back at bit 14, and leaves every other stored field unchanged.
- R4: One measurement counts monitored-clock rising edges during a window of (window field + 1) reference cycles. The count is within ±2 of (field+1) × f_mon / f_ref.
- R5: Bit 25 of the reference code picks the reference. Codes 0 and 1 select the fast reference, and codes 2 and 3 select the slow one.
- R6: The count saturates at 2^CNT_W − 1 and never wraps.
- R7: Until a measurement finishes, the result word reads 0. Once it finishes, bit 31 reads 1, bits [CNT_W-1:0] hold the count, and the value stays constant.
- R8: A measurement starts only on a write with enable = 1 and bit 14 = 0 while soft reset is already clear. Only the first such write after a soft reset starts one; later enable writes leave the result unchanged.
- R9: Soft reset clears the done flag and the count, so the result word reads 0 while it is held.
- R10: Reads from any address other than 0x10 and 0x14 return 0, and writes to any other address, 0x14 included, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register interface clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one bus cycle |
| wrAddr | input | ADDR_W | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | 32 | Read data, combinational from rdAddr |
| refFastClk | input | 1 | Fast reference clock |
| refSlowClk | input | 1 | Slow reference clock |
| monClk | input | 1 | Clock under measurement, from the external mux |
| monSel | output | 7 | Monitor-clock select for the external mux |
| monDiv | output | 2 | Divider code for the external mux |

## Verification
Register effects land on the bus clock edge that samples the write, so the bench reads control fields back one bus cycle after each write. A result only becomes valid after the window ends plus two monitored-clock and two bus-clock synchronizer stages, and that latency depends on both clocks. For that reason the bench polls bit 31 with a bounded timeout rather than sampling at a fixed cycle. The bench checks the count against a ±2 band around window × reference period / monitor period. That band covers the one-cycle uncertainty at each end of the window. Saturation is the exception, and the bench checks it for an exact value.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  localparam int WIN_W = 12;
  localparam int SEL_W = 7;
  localparam int DIV_W = 2;
  localparam int REF_W = 2;
  localparam int CTRL_OFS = 'h10;
  localparam int RES_OFS  = 'h14;

  // strobes and static settings handed from control to datapath
  typedef struct packed {
    logic             startTgl;
    logic             domRst;
    logic             refSlow;
    logic [WIN_W-1:0] winLast;
  } fmCmd_t;
endpackage

// File: rtl/fm_ctrl.sv
`timescale 1ns/1ps
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [SEL_W-1:0]  monSel,
  output logic [DIV_W-1:0]  monDiv,
  output fmCmd_t            cmd,
  input  logic              monDone,
  input  logic [CNT_W-1:0]  monCount
);
  logic [WIN_W-1:0] winReg;
  logic [SEL_W-1:0] selReg;
  logic [DIV_W-1:0] divReg;
  logic [REF_W-1:0] refReg;
  logic             enReg, softRst, armed, startTgl;
  logic             doneMeta, doneSync;
  logic             ctrlWr;
  logic             unusedBits;

  assign ctrlWr     = wrEn && (wrAddr == ADDR_W'(CTRL_OFS));
  assign unusedBits = ^{wrData[31:30], wrData[27:26], wrData[23], wrData[13:12]};

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      winReg <= '0; selReg <= '0; divReg <= '0; refReg <= '0;
      enReg <= 1'b0; softRst <= 1'b0; armed <= 1'b0; startTgl <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (wrData[14]) begin
          softRst <= 1'b1;
        end else begin
          softRst <= 1'b0;
          winReg  <= wrData[WIN_W-1:0];
          selReg  <= wrData[16 +: SEL_W];
          divReg  <= wrData[28 +: DIV_W];
          refReg  <= wrData[24 +: REF_W];
          enReg   <= wrData[15];
          if (wrData[15] && !softRst && !armed) begin
            armed    <= 1'b1;
            startTgl <= ~startTgl;
          end
        end
      end
      if (softRst) begin
        armed    <= 1'b0;
        startTgl <= 1'b0;
      end
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      doneMeta <= 1'b0; doneSync <= 1'b0;
    end else if (softRst) begin
      doneMeta <= 1'b0; doneSync <= 1'b0;
    end else begin
      doneMeta <= monDone; doneSync <= doneMeta;
    end
  end

  assign cmd.startTgl = startTgl;
  assign cmd.domRst   = softRst | ~rstN;
  assign cmd.refSlow  = refReg[1];
  assign cmd.winLast  = winReg;
  assign monSel = selReg;
  assign monDiv = divReg;

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(CTRL_OFS)) begin
      rdData[WIN_W-1:0]  = winReg;
      rdData[14]         = softRst;
      rdData[15]         = enReg;
      rdData[16 +: SEL_W] = selReg;
      rdData[24 +: REF_W] = refReg;
      rdData[28 +: DIV_W] = divReg;
    end else if (rdAddr == ADDR_W'(RES_OFS)) begin
      rdData[31] = doneSync;
      if (doneSync) rdData[CNT_W-1:0] = monCount;
    end
  end

  AST_DONE_NEEDS_START: assert property (@(posedge busClk) disable iff (!rstN)
    doneSync |-> armed); // R8
  AST_ONE_START: assert property (@(posedge busClk) disable iff (!rstN)
    (armed && !softRst) |=> $stable(startTgl)); // R8
  AST_RST_CLEARS: assert property (@(posedge busClk) disable iff (!rstN)
    softRst |=> !doneSync); // R9
endmodule

// File: rtl/fm_datapath.sv
`timescale 1ns/1ps
module fm_datapath
  import fm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             refFastClk,
  input  logic             refSlowClk,
  input  logic             monClk,
  input  fmCmd_t           cmd,
  output logic             monDone,
  output logic [CNT_W-1:0] monCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic refClk;
  assign refClk = cmd.refSlow ? refSlowClk : refFastClk;

  // reference domain: reset release, start detect, window count
  logic [1:0]       refRstPipe;
  logic             refRst;
  logic             stS1, stS2, stPrev, winOpen;
  logic [WIN_W-1:0] remain;

  always_ff @(posedge refClk or posedge cmd.domRst) begin
    if (cmd.domRst) refRstPipe <= 2'b11;
    else            refRstPipe <= {refRstPipe[0], 1'b0};
  end
  assign refRst = refRstPipe[1];

  always_ff @(posedge refClk or posedge refRst) begin
    if (refRst) begin
      stS1 <= 1'b0; stS2 <= 1'b0; stPrev <= 1'b0;
      winOpen <= 1'b0; remain <= '0;
    end else begin
      stS1 <= cmd.startTgl; stS2 <= stS1; stPrev <= stS2;
      if (stS2 != stPrev) begin
        winOpen <= 1'b1;
        remain  <= cmd.winLast;
      end else if (winOpen) begin
        if (remain == '0) winOpen <= 1'b0;
        else              remain  <= remain - 1'b1;
      end
    end
  end

  // monitored domain: reset release, window sync, edge count
  logic [1:0] monRstPipe;
  logic       monRst;
  logic       gS1, gS2, gPrev;

  always_ff @(posedge monClk or posedge cmd.domRst) begin
    if (cmd.domRst) monRstPipe <= 2'b11;
    else            monRstPipe <= {monRstPipe[0], 1'b0};
  end
  assign monRst = monRstPipe[1];

  always_ff @(posedge monClk or posedge monRst) begin
    if (monRst) begin
      gS1 <= 1'b0; gS2 <= 1'b0; gPrev <= 1'b0;
      monCount <= '0; monDone <= 1'b0;
    end else begin
      gS1 <= winOpen; gS2 <= gS1; gPrev <= gS2;
      if (gS2 && monCount != CNT_MAX) monCount <= monCount + 1'b1;
      if (gPrev && !gS2) monDone <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge monClk) disable iff (monRst)
    (monCount == CNT_MAX) |=> (monCount == CNT_MAX)); // R6
  AST_FROZEN: assert property (@(posedge monClk) disable iff (monRst)
    monDone |=> (monDone && $stable(monCount))); // R7
  AST_GATED_COUNT: assert property (@(posedge monClk) disable iff (monRst)
    !gS2 |=> $stable(monCount)); // R4
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
  import fm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              refFastClk,
  input  logic              refSlowClk,
  input  logic              monClk,
  output logic [6:0]        monSel,
  output logic [1:0]        monDiv
);
  fmCmd_t           cmd;
  logic             monDone;
  logic [CNT_W-1:0] monCount;

  fm_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .monSel(monSel), .monDiv(monDiv), .cmd(cmd),
    .monDone(monDone), .monCount(monCount)
  );

  fm_datapath #(.CNT_W(CNT_W)) u_dp (
    .refFastClk(refFastClk), .refSlowClk(refSlowClk), .monClk(monClk),
    .cmd(cmd), .monDone(monDone), .monCount(monCount)
  );
endmodule

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;
  localparam int CW = 12;
  localparam int CMAX = (1 << CW) - 1;
  localparam int FAST_PER = 40;
  localparam int SLOW_PER = 400;

  logic busClk = 0, rstN = 0, wrEn = 0;
  logic [7:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic refFastClk = 0, refSlowClk = 0, monClk = 0;
  logic [6:0] monSel;
  logic [1:0] monDiv;
  int monHalf = 5;
  int nChecks = 0, nBad = 0;
  logic [31:0] rv, first;

  freq_meter #(.ADDR_W(8), .CNT_W(CW)) u_freq_meter (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .refFastClk(refFastClk),
    .refSlowClk(refSlowClk), .monClk(monClk), .monSel(monSel), .monDiv(monDiv));

  always #10 busClk = ~busClk;
  always #(FAST_PER/2) refFastClk = ~refFastClk;
  always #(SLOW_PER/2) refSlowClk = ~refSlowClk;
  always #(monHalf) monClk = ~monClk;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge busClk); wrAddr = a; wrData = d; wrEn = 1;
    @(negedge busClk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge busClk); rdAddr = a; #1 d = rdData;
  endtask

  function automatic logic [31:0] ctrlWord(int refc, int win, int en);
    return (32'(refc) << 24) | (32'(en) << 15) | (32'h2A << 16) | 32'(win);
  endfunction

  task automatic armAndStart(int refc, int win, int half);
    wr(8'h10, 32'h4000);
    monHalf = half;
    repeat (20) @(negedge busClk);
    wr(8'h10, ctrlWord(refc, win, 0));
    repeat (120) @(negedge busClk);
    wr(8'h10, ctrlWord(refc, win, 1));
  endtask

  task automatic waitDone(output logic [31:0] d);
    d = 0;
    for (int i = 0; i < 30000; i++) begin
      rd(8'h14, d);
      if (d[31]) break;
    end
  endtask

  task automatic measure(input string req, int refc, int win, int half);
    int per, expv, got;
    logic [31:0] d;
    per = refc[1] ? SLOW_PER : FAST_PER;
    expv = ((win + 1) * per) / (2 * half);
    if (expv > CMAX) expv = CMAX;
    armAndStart(refc, win, half);
    waitDone(d);
    got = int'(d[CW-1:0]);
    check(req, d[31] == 1'b1, int'(d[31]), 1);
    if (expv == CMAX)
      check(req, got == CMAX, got, CMAX);
    else
      check(req, (got >= expv - 2) && (got <= expv + 2), got, expv);
  endtask

  initial begin
    #3000000;
    nChecks++; nBad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge busClk);
    rstN = 1;
    // R1 reset state
    rd(8'h10, rv); check("R1", rv == 0, int'(rv), 0);
    rd(8'h14, rv); check("R1", rv == 0, int'(rv), 0);
    check("R1", monSel == 0 && monDiv == 0, int'({monDiv, monSel}), 0);

    // R2 field store and readback
    wr(8'h10, 32'hFFFF_BFFF);
    rd(8'h10, rv); check("R2", rv == 32'h337F_8FFF, int'(rv), 32'h337F_8FFF);
    check("R2", monSel == 7'h7F && monDiv == 2'd3, int'({monDiv, monSel}), 9'h1FF);
    wr(8'h10, 32'h2015_0123);
    rd(8'h10, rv); check("R2", rv == 32'h2015_0123, int'(rv), 32'h2015_0123);
    check("R2", monSel == 7'h15 && monDiv == 2'd2, int'({monDiv, monSel}), 9'h115);

    // R3 soft reset keeps fields
    wr(8'h10, 32'h0000_4000);
    rd(8'h10, rv); check("R3", rv == 32'h2015_4123, int'(rv), 32'h2015_4123);

    // R10 unmapped and read-only offsets
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h10, rv); check("R10", rv == 32'h2015_4123, int'(rv), 32'h2015_4123);
    rd(8'h20, rv); check("R10", rv == 0, int'(rv), 0);
    rd(8'h14, rv); check("R10", rv == 0, int'(rv), 0);

    // R4 fast reference, several ratios and windows
    measure("R4", 0, 511, 5);
    measure("R4", 0, 255, 8);
    measure("R4", 0, 0, 5);
    measure("R4", 0, 4095, 60);
    // R5 reference code choice
    measure("R5", 2, 99, 5);
    measure("R5", 1, 99, 5);
    measure("R5", 3, 9, 20);
    // R6 saturation
    measure("R6", 0, 2047, 5);

    // R7 zero while running, then stable
    armAndStart(0, 1023, 5);
    repeat (100) @(negedge busClk);
    rd(8'h14, rv); check("R7", rv == 0, int'(rv), 0);
    waitDone(first);
    repeat (300) @(negedge busClk);
    rd(8'h14, rv); check("R7", rv == first, int'(rv), int'(first));

    // R8 second enable without soft reset ignored
    wr(8'h10, ctrlWord(0, 63, 0));
    wr(8'h10, ctrlWord(0, 63, 1));
    repeat (400) @(negedge busClk);
    rd(8'h14, rv); check("R8", rv == first, int'(rv), int'(first));

    // R8 enable written while soft reset held does not start
    wr(8'h10, 32'h4000);
    wr(8'h10, 32'h4000 | ctrlWord(0, 3, 1));
    repeat (400) @(negedge busClk);
    rd(8'h14, rv); check("R8", rv == 0, int'(rv), 0);

    // R9 soft reset clears result
    rd(8'h10, rv); check("R9", rv[14] == 1'b1, int'(rv[14]), 1);
    wr(8'h10, ctrlWord(0, 3, 0));
    repeat (100) @(negedge busClk);
    rd(8'h14, rv); check("R9", rv == 0, int'(rv), 0);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule